// File: doc/BRIEF.md
# NAND Flash Operation Sequencer

This block sits between a 16-bit host register bus and a raw NAND flash device. Software loads a flash command byte, an address byte, a buffer-area index and a configuration word. It then starts exactly one elementary flash operation by writing a one-hot code to a launch register. The sequencer drives the chip select, the command and address latch enables, the write and read strobes and the data bus for that one operation. It then raises a completion flag, which can also drive a maskable interrupt.

Page data moves between the flash and an internal buffer RAM that the host sees at the low end of its address space. The RAM holds four main areas of 512 bytes and four spare areas of 16 bytes. A page transfer moves either the whole main area followed by its spare area, or the spare area alone. The area pair is chosen by the buffer-select register. Read-status and read-ID results also land in the selected main area. The flash ready line is watched in hardware, so a page read never strobes the device while it is still busy.

The flash data bus appears as separate output, output-enable and input vectors, which a pad ring combines into one bidirectional bus. A parameter selects an 8-bit or a 16-bit flash bus. With an 8-bit bus only the low byte of the output vector is used.

Top module: `nand_seq`

## Requirements
- R1: After reset the chip select, write strobe and read strobe are high, the data output enable and the interrupt are low, the configuration register reads 0x0010 (interrupt masked) and the launch register reads 0x0000.
- R2: Writing 0x0001 to the launch register (offset 0xC08) produces one write strobe with the command latch high, carrying the low byte of the command register (0xC00). Writing 0x0002 produces one write strobe with the address latch high, carrying the low byte of the address register (0xC02).
- R3: Bit 15 of the launch register becomes 1 when the started operation finishes. A launch-register write with bit 15 at 0 clears it. A write with bit 15 at 1 and no operation bit set leaves it at 1.
- R4: The interrupt output is high exactly while the completion flag is 1 and configuration bit 4 (offset 0xC06) is 0.
- R5: Main area k occupies host byte offsets 0x200*k to 0x200*k+0x1FF, and spare area k occupies 0x800+0x10*k to 0x80F+0x10*k. Buffer words are readable and writable from the host. The buffer-select register sits at offset 0xC04.
- R6: Launch code 0x0008 with configuration bit 2 clear reads 528 bytes from the flash (8-bit bus). Byte n goes to main-area byte n for n below 512, and to spare-area byte n-512 after that. Even bytes go in the low half of each 16-bit word.
- R7: With configuration bit 2 set, a page transfer moves only the 16 spare bytes, and the selected main area is left unchanged.
- R8: Launch code 0x0004 writes the selected area pair to the flash in the same byte order as R6, with 528 write strobes. The completion flag rises only after the last strobe.
- R9: A page read (0x0008) issues no read strobe while the ready input is low, and starts once it is high.
- R10: Launch code 0x0020 reads one status byte into word 0 of the selected main area, with the upper byte of that word set to 0.
- R11: Launch code 0x0010 reads four ID bytes into the selected main area. On an 8-bit bus they are packed two per word. On a 16-bit bus each byte sits in the low half of its own word, and the upper half is 0.
- R12: Configuration bit 7 holds chip select low while idle. When it is clear, chip select is low only during an operation.
- R13: A launch-register write while an operation runs has no effect. While running, launch-register bit 14 reads 1 and bits 5:0 show the running code.
- R14: The data output enable is high only during command, address and page-write operations, and never while the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| h_wr | input | 1 | Host write strobe |
| h_addr | input | HAW | Host byte address |
| h_wdata | input | 16 | Host write data |
| h_rdata | output | 16 | Host read data (combinational on h_addr) |
| irq | output | 1 | Completion interrupt |
| fl_cs_n | output | 1 | Flash chip select, active low |
| fl_cmd_latch | output | 1 | Command latch enable |
| fl_addr_latch | output | 1 | Address latch enable |
| fl_wr_n | output | 1 | Write strobe, active low |
| fl_rd_n | output | 1 | Read strobe, active low |
| fl_dq_o | output | 16 | Data toward the flash |
| fl_dq_oe | output | 1 | Drive enable for fl_dq_o |
| fl_dq_i | input | 16 | Data from the flash |
| fl_ready | input | 1 | Flash ready (high) or busy (low) |

## Verification
The hardest state to reach from the ports is an operation that is started but stalled. Only in that state can the busy readback and the ignoring of a second launch be seen. The bench holds the ready input low and starts a page read, so the sequencer sits waiting without strobing. It then checks the launch register, chip select and the bus enable, and fires a second launch, before releasing ready and confirming that only the original spare-only transfer ran. A second instance built for a 16-bit bus shares every input, so the unpacked ID layout is compared against the packed one from the same flash responses.

// File: rtl/nand_seq.sv
module nand_seq #(
  parameter int BUS16       = 0,
  parameter int MAIN_BYTES  = 512,
  parameter int SPARE_BYTES = 16,
  parameter int NAREA       = 4,
  parameter int ID_BYTES    = 4,
  parameter int TLOW        = 2,
  parameter int THIGH       = 1,
  parameter int HAW         = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           h_wr,
  input  logic [HAW-1:0] h_addr,
  input  logic [15:0]    h_wdata,
  output logic [15:0]    h_rdata,
  output logic           irq,
  output logic           fl_cs_n,
  output logic           fl_cmd_latch,
  output logic           fl_addr_latch,
  output logic           fl_wr_n,
  output logic           fl_rd_n,
  output logic [15:0]    fl_dq_o,
  output logic           fl_dq_oe,
  input  logic [15:0]    fl_dq_i,
  input  logic           fl_ready
);
  localparam int MAIN_W      = MAIN_BYTES / 2;
  localparam int SPARE_W     = SPARE_BYTES / 2;
  localparam int MEM_W       = NAREA * (MAIN_W + SPARE_W);
  localparam int BUF_BYTES   = 2 * MEM_W;
  localparam int SPARE_BASE  = NAREA * MAIN_W;
  localparam int AREA_W      = (NAREA > 1) ? $clog2(NAREA) : 1;
  localparam int PAGE_ITEMS  = BUS16 ? (MAIN_W + SPARE_W) : (MAIN_BYTES + SPARE_BYTES);
  localparam int SPARE_ITEMS = BUS16 ? SPARE_W : SPARE_BYTES;
  localparam int CW          = $clog2(PAGE_ITEMS + ID_BYTES + 1);
  localparam int TW          = $clog2(TLOW + THIGH + 1);
  localparam int MW          = $clog2(MEM_W);

  localparam logic [HAW-1:0] A_CMD  = HAW'(32'hC00);
  localparam logic [HAW-1:0] A_ADR  = HAW'(32'hC02);
  localparam logic [HAW-1:0] A_AREA = HAW'(32'hC04);
  localparam logic [HAW-1:0] A_CFG  = HAW'(32'hC06);
  localparam logic [HAW-1:0] A_GO   = HAW'(32'hC08);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_LO, S_HI} st_t;

  logic [15:0]       mem [MEM_W];
  logic [15:0]       cmd_q, adr_q;
  logic [AREA_W-1:0] area_q, ar_q;
  logic              sp_en, irq_mask, force_ce;
  logic              done_q, sp_q;
  logic [5:0]        op_q;
  st_t               st;
  logic [TW-1:0]     tcnt;
  logic [CW-1:0]     idx, last_q;
  logic [MW-1:0]     eidx;
  logic [MW-1:0]     hidx;

  wire busy     = (st != S_IDLE);
  wire wr_type  = op_q[0] | op_q[1] | op_q[2];
  wire go_wr    = h_wr && (h_addr == A_GO);
  wire launch   = go_wr && !busy && $onehot(h_wdata[5:0]);
  wire lo_end   = (st == S_LO) && (tcnt == TW'(TLOW - 1));
  wire hi_end   = (st == S_HI) && (tcnt == TW'(THIGH - 1));
  wire finish   = hi_end && (idx == last_q);
  wire cap      = lo_end && !wr_type;
  wire lane     = (BUS16 == 0) && idx[0];
  wire in_buf   = int'(h_addr) < BUF_BYTES;
  wire full_wr  = (BUS16 != 0) || op_q[5];

  assign hidx = h_addr[MW:1];

  // item count for the operation being launched
  logic [CW-1:0] n_last;
  always_comb begin
    if (h_wdata[2] || h_wdata[3])
      n_last = sp_en ? CW'(SPARE_ITEMS - 1) : CW'(PAGE_ITEMS - 1);
    else if (h_wdata[4])
      n_last = CW'(ID_BYTES - 1);
    else
      n_last = '0;
  end

  // buffer word addressed by the engine
  always_comb begin
    int w, e;
    w = (BUS16 != 0) ? int'(idx) : int'(idx >> 1);
    if (op_q[5])       e = int'(ar_q) * MAIN_W;
    else if (op_q[4])  e = int'(ar_q) * MAIN_W + w;
    else if (sp_q)     e = SPARE_BASE + int'(ar_q) * SPARE_W + w;
    else if (w < MAIN_W) e = int'(ar_q) * MAIN_W + w;
    else               e = SPARE_BASE + int'(ar_q) * SPARE_W + w - MAIN_W;
    eidx = MW'(e);
  end

  // host registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q    <= '0;
      adr_q    <= '0;
      area_q   <= '0;
      sp_en    <= 1'b0;
      irq_mask <= 1'b1;
      force_ce <= 1'b0;
    end else if (h_wr) begin
      if (h_addr == A_CMD)  cmd_q  <= h_wdata;
      if (h_addr == A_ADR)  adr_q  <= h_wdata;
      if (h_addr == A_AREA) area_q <= h_wdata[AREA_W-1:0];
      if (h_addr == A_CFG) begin
        sp_en    <= h_wdata[2];
        irq_mask <= h_wdata[4];
        force_ce <= h_wdata[7];
      end
    end
  end

  // sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      op_q   <= '0;
      sp_q   <= 1'b0;
      ar_q   <= '0;
      idx    <= '0;
      last_q <= '0;
      tcnt   <= '0;
    end else begin
      case (st)
        S_IDLE: if (launch) begin
          op_q   <= h_wdata[5:0];
          sp_q   <= sp_en;
          ar_q   <= area_q;
          idx    <= '0;
          tcnt   <= '0;
          last_q <= n_last;
          st     <= h_wdata[3] ? S_WAIT : S_LO;
        end
        S_WAIT: if (fl_ready) st <= S_LO;
        S_LO: begin
          if (lo_end) begin
            tcnt <= '0;
            st   <= S_HI;
          end else tcnt <= tcnt + 1'b1;
        end
        default: begin
          if (hi_end) begin
            tcnt <= '0;
            if (idx == last_q) st <= S_IDLE;
            else begin
              idx <= idx + 1'b1;
              st  <= S_LO;
            end
          end else tcnt <= tcnt + 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else if (finish) done_q <= 1'b1;
    else if (go_wr && !busy) done_q <= done_q & h_wdata[15];
  end

  // buffer RAM: host port, engine capture port
  always_ff @(posedge clk) begin
    if (h_wr && in_buf) mem[hidx] <= h_wdata;
    if (cap) begin
      if (full_wr)
        mem[eidx] <= (op_q[3] && BUS16 != 0) ? fl_dq_i : {8'h00, fl_dq_i[7:0]};
      else if (lane)
        mem[eidx][15:8] <= fl_dq_i[7:0];
      else
        mem[eidx][7:0] <= fl_dq_i[7:0];
    end
  end

  // host readback
  always_comb begin
    h_rdata = '0;
    if (h_addr == A_CMD)       h_rdata = cmd_q;
    else if (h_addr == A_ADR)  h_rdata = adr_q;
    else if (h_addr == A_AREA) h_rdata = 16'(area_q);
    else if (h_addr == A_CFG)  h_rdata = {8'h00, force_ce, 2'b00, irq_mask, 1'b0, sp_en, 2'b00};
    else if (h_addr == A_GO)   h_rdata = {done_q, busy, 8'h00, busy ? op_q : 6'h00};
    else if (in_buf)           h_rdata = mem[hidx];
  end

  // flash pins
  always_comb begin
    fl_dq_o = '0;
    if (op_q[0])      fl_dq_o = {8'h00, cmd_q[7:0]};
    else if (op_q[1]) fl_dq_o = {8'h00, adr_q[7:0]};
    else if (op_q[2]) begin
      if (BUS16 != 0) fl_dq_o = mem[eidx];
      else            fl_dq_o = lane ? {8'h00, mem[eidx][15:8]} : {8'h00, mem[eidx][7:0]};
    end
  end

  assign fl_cs_n       = !(busy || force_ce);
  assign fl_cmd_latch  = busy && op_q[0];
  assign fl_addr_latch = busy && op_q[1];
  assign fl_wr_n       = !((st == S_LO) && wr_type);
  assign fl_rd_n       = !((st == S_LO) && !wr_type);
  assign fl_dq_oe      = busy && wr_type;
  assign irq           = done_q && !irq_mask;

  AST_DONE_ON_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_q); // R3
  AST_IRQ_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done_q); // R4
  AST_WAIT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(fl_rd_n) && op_q[3] && idx == '0) |-> $past(fl_ready)); // R9
  AST_CE_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_wr_n || !fl_rd_n) |-> !fl_cs_n); // R12
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && go_wr) |=> $stable(op_q)); // R13
  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_rd_n |-> !fl_dq_oe); // R14
endmodule

// File: tb/nand_seq_tb.sv
`timescale 1ns/1ps
module nand_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic h_wr = 1'b0;
  logic [11:0] h_addr = '0;
  logic [15:0] h_wdata = '0;
  logic [15:0] h_rdata, h_rdata16;
  logic irq, cs_n, cle, ale, wr_n, rd_n, oe;
  logic irq16, cs_n16, cle16, ale16, wr_n16, rd_n16, oe16;
  logic [15:0] dq_o, dq_o16;
  logic [15:0] fl_dq_i = '0;
  logic fl_ready = 1'b1;

  int n_tests = 0;
  int n_fail = 0;
  int rd_cnt = 0;
  int wcnt = 0;
  logic [10:0] wlog [1024];

  always #2.5 clk = ~clk;

  nand_seq u_dut (
    .clk(clk), .rst_n(rst_n), .h_wr(h_wr), .h_addr(h_addr), .h_wdata(h_wdata),
    .h_rdata(h_rdata), .irq(irq), .fl_cs_n(cs_n), .fl_cmd_latch(cle),
    .fl_addr_latch(ale), .fl_wr_n(wr_n), .fl_rd_n(rd_n), .fl_dq_o(dq_o),
    .fl_dq_oe(oe), .fl_dq_i(fl_dq_i), .fl_ready(fl_ready));

  nand_seq #(.BUS16(1)) u_dut_w16 (
    .clk(clk), .rst_n(rst_n), .h_wr(h_wr), .h_addr(h_addr), .h_wdata(h_wdata),
    .h_rdata(h_rdata16), .irq(irq16), .fl_cs_n(cs_n16), .fl_cmd_latch(cle16),
    .fl_addr_latch(ale16), .fl_wr_n(wr_n16), .fl_rd_n(rd_n16), .fl_dq_o(dq_o16),
    .fl_dq_oe(oe16), .fl_dq_i(fl_dq_i), .fl_ready(fl_ready));

  function automatic logic [7:0] pb(int k);
    return 8'(k * 7 + 3);
  endfunction

  // flash model: new byte on each falling read strobe
  always @(negedge rd_n) if (rst_n) begin
    fl_dq_i = {8'hA5, pb(rd_cnt)};
    rd_cnt = rd_cnt + 1;
  end

  // write-cycle log: {oe, cmd latch, addr latch, byte}
  always @(posedge wr_n) if (rst_n) begin
    if (wcnt < 1024) wlog[wcnt] = {oe, cle, ale, dq_o[7:0]};
    wcnt = wcnt + 1;
  end

  // {op code, register value, expected byte}
  localparam logic [31:0] VEC [6] = '{
    {8'h01, 16'h0090, 8'h90}, {8'h02, 16'h0000, 8'h00},
    {8'h01, 16'h0070, 8'h70}, {8'h02, 16'h005A, 8'h5A},
    {8'h01, 16'hAAFF, 8'hFF}, {8'h02, 16'h1234, 8'h34}};

  task automatic hw(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk); h_wr = 1'b1; h_addr = a; h_wdata = d;
    @(negedge clk); h_wr = 1'b0;
  endtask

  task automatic hr(input logic [11:0] a, output logic [15:0] d);
    @(negedge clk); h_addr = a; #1; d = h_rdata;
  endtask

  task automatic hr16(input logic [11:0] a, output logic [15:0] d);
    @(negedge clk); h_addr = a; #1; d = h_rdata16;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_done(input string req);
    logic [15:0] v;
    for (int i = 0; i < 6000; i++) begin
      hr(12'hC08, v);
      if (v[15]) return;
    end
    check(req, 32'(v[15]), 32'd1);
  endtask

  task automatic wait_idle();
    logic [15:0] v, v16;
    for (int i = 0; i < 6000; i++) begin
      hr(12'hC08, v); hr16(12'hC08, v16);
      if (!v[14] && !v16[14]) return;
    end
    check("idle", 32'(v[14] | v16[14]), 32'd0);
  endtask

  initial begin
    #(5.0 * 190000);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int w0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 cs_n", 32'(cs_n), 32'd1);
    check("R1 wr_n/rd_n", {wr_n, rd_n}, 32'd3);
    check("R1 oe/irq", {oe, irq}, 32'd0);
    hr(12'hC06, v); check("R1 cfg", v, 32'h0010);
    hr(12'hC08, v); check("R1 launch", v, 32'h0000);

    // R2 command and address cycles from the vector table
    for (int i = 0; i < 6; i++) begin
      logic [7:0] op;
      op = VEC[i][31:24];
      hw(op == 8'h01 ? 12'hC00 : 12'hC02, VEC[i][23:8]);
      w0 = wcnt;
      hw(12'hC08, {8'h00, op});
      wait_done("R2 done");
      check("R2 strobe count", wcnt - w0, 32'd1);
      check("R2 cycle", 32'(wlog[w0]), {21'd0, 1'b1, op == 8'h01, op == 8'h02, VEC[i][7:0]});
    end

    // R3 completion flag handling
    hw(12'hC08, 16'h8000);
    hr(12'hC08, v); check("R3 keep", 32'(v[15]), 32'd1);
    // R4 interrupt masking
    check("R4 masked", 32'(irq), 32'd0);
    hw(12'hC06, 16'h0000);
    @(negedge clk); check("R4 unmasked", 32'(irq), 32'd1);
    hw(12'hC08, 16'h0000);
    hr(12'hC08, v); check("R3 clear", 32'(v[15]), 32'd0);
    check("R4 after clear", 32'(irq), 32'd0);
    hw(12'hC06, 16'h0010);

    // R12 forced chip select
    hw(12'hC06, 16'h0090);
    @(negedge clk); check("R12 forced", 32'(cs_n), 32'd0);
    hw(12'hC06, 16'h0010);
    @(negedge clk); check("R12 released", 32'(cs_n), 32'd1);

    // R5 host buffer access
    hw(12'h83E, 16'hC0DE);
    hr(12'h83E, v); check("R5 spare3 last word", v, 32'hC0DE);

    // R6 full page read into area 2
    wait_idle();
    hw(12'hC04, 16'h0002);
    rd_cnt = 0;
    hw(12'hC08, 16'h0008);
    wait_done("R6 done");
    check("R6 reads", rd_cnt, 32'd528);
    hr(12'h400, v); check("R6 main2 w0", v, {pb(1), pb(0)});
    hr(12'h5FE, v); check("R6 main2 last", v, {pb(511), pb(510)});
    hr(12'h820, v); check("R5 R6 spare2 w0", v, {pb(513), pb(512)});
    hr(12'h82E, v); check("R6 spare2 last", v, {pb(527), pb(526)});

    // R9 R7 R13 spare-only read held by busy flash
    wait_idle();
    hw(12'h200, 16'hBEEF);
    hw(12'hC04, 16'h0001);
    hw(12'hC06, 16'h0014);
    fl_ready = 1'b0;
    rd_cnt = 0;
    w0 = wcnt;
    hw(12'hC08, 16'h0008);
    repeat (20) @(negedge clk);
    check("R9 no strobe while busy", rd_cnt, 32'd0);
    check("R12 cs during op", 32'(cs_n), 32'd0);
    check("R14 bus released", 32'(oe), 32'd0);
    hr(12'hC08, v); check("R13 busy readback", v, 32'h4008);
    hw(12'hC08, 16'h0001);
    hr(12'hC08, v); check("R13 launch ignored", v, 32'h4008);
    @(negedge clk); fl_ready = 1'b1;
    wait_done("R9 done");
    check("R7 reads", rd_cnt, 32'd16);
    check("R13 no extra cycle", wcnt - w0, 32'd0);
    hr(12'h810, v); check("R7 spare1 w0", v, {pb(1), pb(0)});
    hr(12'h200, v); check("R7 main untouched", v, 32'hBEEF);

    // R8 page write from area 3
    wait_idle();
    hw(12'hC06, 16'h0010);
    hw(12'hC04, 16'h0003);
    hw(12'h600, 16'h2211);
    hw(12'h602, 16'h4433);
    hw(12'h830, 16'h6655);
    w0 = wcnt;
    hw(12'hC08, 16'h0004);
    wait_done("R8 done");
    check("R8 strobes at completion", wcnt - w0, 32'd528);
    check("R8 byte0", 32'(wlog[w0]), 32'h411);
    check("R8 byte1", 32'(wlog[w0 + 1]), 32'h422);
    check("R8 byte2", 32'(wlog[w0 + 2]), 32'h433);
    check("R8 spare byte0", 32'(wlog[w0 + 512]), 32'h455);
    check("R8 spare byte1", 32'(wlog[w0 + 513]), 32'h466);

    // R10 status into main area 1
    wait_idle();
    hw(12'hC04, 16'h0001);
    hw(12'h200, 16'hFFFF);
    rd_cnt = 0;
    hw(12'hC08, 16'h0020);
    wait_done("R10 done");
    hr(12'h200, v); check("R10 status word", v, {8'h00, pb(0)});

    // R11 ID layout on both bus widths
    wait_idle();
    hw(12'hC04, 16'h0000);
    rd_cnt = 0;
    hw(12'hC08, 16'h0010);
    wait_done("R11 done");
    wait_idle();
    check("R11 reads", rd_cnt, 32'd4);
    hr(12'h000, v); check("R11 packed w0", v, {pb(1), pb(0)});
    hr(12'h002, v); check("R11 packed w1", v, {pb(3), pb(2)});
    hr16(12'h000, v); check("R11 wide w0", v, {8'h00, pb(0)});
    hr16(12'h002, v); check("R11 wide w1", v, {8'h00, pb(1)});
    hr16(12'h006, v); check("R11 wide w3", v, {8'h00, pb(3)});

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule